// File: doc/BRIEF.md
# USB Endpoint Bank Error Detector

This block follows the data banks of a single USB device endpoint. A packet engine produces or consumes a bank on one side, and the CPU does the opposite on the other side. The block keeps the number of occupied banks and a producer pointer and a consumer pointer that alternate between the banks. For OUT endpoints it also keeps the byte count stored in each bank. It detects two error conditions. The first is an underflow, which is reported only for isochronous endpoints. The second is an overflow, which is reported for any endpoint type. The block does not store packet data and has no register bus.

On an IN endpoint, the CPU fills a bank and then marks it ready with a validate strobe. Each IN token from the host consumes one ready bank. If the bank set is empty on an isochronous endpoint, the block asks the packet engine for an automatic zero-length packet. On an OUT endpoint, an accepted data packet fills a bank. A packet longer than the bank is still accepted, and it is cut down to the bank size. The CPU frees a bank with a release strobe after it has read the bank.

There are three status flags, and software clears them by writing ones. Each flag drives the shared interrupt line only while its enable bit is set. A configuration input selects whether one bank or two banks are in use.

Top module: `ep_bank_guard`

## Requirements
- R1: While reset is held and right after it, the bank set reads empty and not full, `flags` is 0, `irq` is 0, `zlp_req` is 0 and `rd_count` is 0.
- R2: A bank is filled by `cpu_validate` on an IN endpoint or by `pk_out_pkt` on an OUT endpoint. `bank_full` is set once 1 bank is occupied (`cfg_two_banks`=0) or once 2 banks are occupied (`cfg_two_banks`=1). A fill strobe that arrives while the set is full leaves the occupancy unchanged. Occupancy changes become visible the cycle after the strobe.
- R3: An IN token on an isochronous IN endpoint with no occupied bank sets `flags[0]` (underflow) in the next cycle. It also raises `zlp_req` for exactly that one cycle.
- R4: An IN token on an empty non-isochronous IN endpoint sets no flag and requests no zero-length packet.
- R5: An OUT packet that arrives while all banks are full is discarded, so occupancy and `rd_count` do not change. On an isochronous endpoint it also sets `flags[0]`. On any other endpoint type it sets no flag.
- R6: An accepted OUT packet sets `flags[2]` (received OUT). If its length is greater than BANK_BYTES, it also sets `flags[1]` (overflow), and the stored count saturates at BANK_BYTES. Otherwise the stored count equals the packet length. This holds for every endpoint type.
- R7: With two banks, `rd_count` shows the count of the oldest unreleased OUT bank. Packets are therefore presented in the order they arrived.
- R8: A CPU release while the set is empty is ignored. It changes no occupancy and sets no flag, so a CPU action never causes an error.
- R9: Each flag stays set until its bit in `flag_clr` is pulsed. A clear in the same cycle as a set leaves the flag at 0.
- R10: `irq` is 1 exactly when some flag bit and the matching `flag_en` bit are both 1.
- R11: A strobe that belongs to the other direction is ignored. This covers an IN token or validate on an OUT endpoint, and an OUT packet or release on an IN endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_iso | input | 1 | Endpoint is isochronous |
| cfg_dir_in | input | 1 | 1 selects an IN endpoint, 0 selects an OUT endpoint |
| cfg_two_banks | input | 1 | 1 uses two banks, 0 uses one bank |
| pk_in_token | input | 1 | IN token strobe from the packet engine |
| pk_out_pkt | input | 1 | OUT data packet received strobe |
| pk_out_len | input | LEN_W | Byte count of the OUT packet |
| cpu_validate | input | 1 | CPU marks a written IN bank ready |
| cpu_release | input | 1 | CPU frees a read OUT bank |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| flag_en | input | 3 | Interrupt enables for the flags |
| bank_full | output | 1 | All active banks occupied |
| bank_empty | output | 1 | No bank occupied |
| rd_count | output | CNT_W | Stored byte count of the bank at the consumer pointer |
| zlp_req | output | 1 | One-cycle request for an automatic zero-length packet |
| flags | output | 3 | Sticky flags: bit 0 underflow, bit 1 overflow, bit 2 received OUT |
| irq | output | 1 | Endpoint interrupt |

## Verification
The assertions check the following on every cycle:
- `bank_full` and `bank_empty` are never both set.
- Every `zlp_req` pulse has a legal cause: an isochronous IN endpoint received a token while empty.
- Underflow rises only on isochronous endpoints.
- Flags are sticky, and a clear wins over a same-cycle set.
- A release on an empty OUT set keeps it empty.
- The interrupt stays low while no flag is set.
- `rd_count` never exceeds the bank size.

Only the bench scenarios can show the following:
- Correct saturated counts across a sweep of packet lengths.
- The order in which ping-pong banks are presented.
- Discarding of a packet that arrives while the set is full.
- Correct behaviour of each endpoint type and bank mode.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  localparam int NFLAGS  = 3;
  localparam int FLG_UF  = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_RX  = 2;

  typedef struct packed {
    logic fill;
    logic drain;
    logic uf;
    logic ovf;
    logic rx;
    logic zlp;
  } ep_evt_t;
endpackage

// File: rtl/ep_bank_evt.sv
module ep_bank_evt
  import ep_bank_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int LEN_W      = 11
) (
  input  logic             cfg_iso,
  input  logic             cfg_dir_in,
  input  logic             full,
  input  logic             empty,
  input  logic             pk_in_token,
  input  logic             pk_out_pkt,
  input  logic [LEN_W-1:0] pk_out_len,
  input  logic             cpu_validate,
  input  logic             cpu_release,
  output ep_evt_t          evt
);
  logic too_long;
  assign too_long = pk_out_len > LEN_W'(BANK_BYTES);

  always_comb begin
    evt = '0;
    if (cfg_dir_in) begin
      // producer is the CPU, consumer is the host
      evt.fill  = cpu_validate & ~full;
      evt.drain = pk_in_token & ~empty;
      evt.uf    = cfg_iso & pk_in_token & empty;
      evt.zlp   = cfg_iso & pk_in_token & empty;
    end else begin
      // producer is the host, consumer is the CPU
      evt.fill  = pk_out_pkt & ~full;
      evt.drain = cpu_release & ~empty;
      evt.uf    = cfg_iso & pk_out_pkt & full;
      evt.ovf   = pk_out_pkt & ~full & too_long;
      evt.rx    = pk_out_pkt & ~full;
    end
  end
endmodule

// File: rtl/ep_bank_store.sv
module ep_bank_store #(
  parameter int BANK_BYTES = 64,
  parameter int LEN_W      = 11,
  localparam int CNT_W     = $clog2(BANK_BYTES + 1),
  localparam int NBANKS    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_banks,
  input  logic             fill,
  input  logic             drain,
  input  logic             store_cnt,
  input  logic [LEN_W-1:0] wr_len,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] rd_count
);
  logic [1:0]       level_q, level_d;
  logic             wr_ptr_q, wr_ptr_d;
  logic             rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] sat_len;
  logic [CNT_W-1:0] cnt_q [NBANKS];

  assign sat_len = (wr_len > LEN_W'(BANK_BYTES)) ? CNT_W'(BANK_BYTES)
                                                : wr_len[CNT_W-1:0];
  assign full     = (level_q == (two_banks ? 2'd2 : 2'd1));
  assign empty    = (level_q == 2'd0);
  assign rd_count = cnt_q[rd_ptr_q];

  always_comb begin
    level_d  = level_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (fill && !drain)      level_d = level_q + 2'd1;
    else if (drain && !fill) level_d = level_q - 2'd1;
    if (fill)  wr_ptr_d = two_banks ? ~wr_ptr_q : 1'b0;
    if (drain) rd_ptr_d = two_banks ? ~rd_ptr_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      wr_ptr_q <= 1'b0;
      rd_ptr_q <= 1'b0;
    end else begin
      level_q  <= level_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic wr_en;
    assign wr_en = fill && store_cnt && (wr_ptr_q == 1'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q[b] <= '0;
      else if (wr_en) cnt_q[b] <= sat_len;
    end
  end
endmodule

// File: rtl/ep_bank_flags.sv
module ep_bank_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] flag_q, flag_d;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr[i])      flag_d[i] = 1'b0;
      else if (set[i]) flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en);
endmodule

// File: rtl/ep_bank_guard.sv
module ep_bank_guard
  import ep_bank_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int LEN_W      = 11,
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_iso,
  input  logic              cfg_dir_in,
  input  logic              cfg_two_banks,
  input  logic              pk_in_token,
  input  logic              pk_out_pkt,
  input  logic [LEN_W-1:0]  pk_out_len,
  input  logic              cpu_validate,
  input  logic              cpu_release,
  input  logic [NFLAGS-1:0] flag_clr,
  input  logic [NFLAGS-1:0] flag_en,
  output logic              bank_full,
  output logic              bank_empty,
  output logic [CNT_W-1:0]  rd_count,
  output logic              zlp_req,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  ep_evt_t           evt;
  logic [NFLAGS-1:0] flag_set;
  logic              zlp_q;

  ep_bank_evt #(.BANK_BYTES(BANK_BYTES), .LEN_W(LEN_W)) u_evt (
    .cfg_iso      (cfg_iso),
    .cfg_dir_in   (cfg_dir_in),
    .full         (bank_full),
    .empty        (bank_empty),
    .pk_in_token  (pk_in_token),
    .pk_out_pkt   (pk_out_pkt),
    .pk_out_len   (pk_out_len),
    .cpu_validate (cpu_validate),
    .cpu_release  (cpu_release),
    .evt          (evt)
  );

  ep_bank_store #(.BANK_BYTES(BANK_BYTES), .LEN_W(LEN_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_banks (cfg_two_banks),
    .fill      (evt.fill),
    .drain     (evt.drain),
    .store_cnt (~cfg_dir_in),
    .wr_len    (pk_out_len),
    .full      (bank_full),
    .empty     (bank_empty),
    .rd_count  (rd_count)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FLG_UF]  = evt.uf;
    flag_set[FLG_OVF] = evt.ovf;
    flag_set[FLG_RX]  = evt.rx;
  end

  ep_bank_flags #(.NF(NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .en    (flag_en),
    .flags (flags),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zlp_q <= 1'b0;
    else        zlp_q <= evt.zlp;
  end
  assign zlp_req = zlp_q;
endmodule

// File: rtl/ep_bank_guard_chk.sv
module ep_bank_guard_chk #(
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_iso,
  input logic             cfg_dir_in,
  input logic             pk_in_token,
  input logic             pk_out_pkt,
  input logic             cpu_release,
  input logic [2:0]       flag_clr,
  input logic             bank_full,
  input logic             bank_empty,
  input logic [CNT_W-1:0] rd_count,
  input logic             zlp_req,
  input logic [2:0]       flags,
  input logic             irq
);
  p_full_empty_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_full && bank_empty));

  p_zlp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_req |-> $past(cfg_iso && cfg_dir_in && pk_in_token && bank_empty));

  p_uf_iso_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(cfg_iso));

  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flag_clr[1]) |=> flags[1]);

  p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr[0] |=> !flags[0]);

  p_release_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir_in && cpu_release && bank_empty && !pk_out_pkt) |=> bank_empty);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 3'b000) |-> !irq);

  always @(negedge clk) begin
    if (rst_n) begin
      p_count_sat_r6: assert (rd_count <= CNT_W'(BANK_BYTES));
    end
  end
endmodule

bind ep_bank_guard ep_bank_guard_chk #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_iso     (cfg_iso),
  .cfg_dir_in  (cfg_dir_in),
  .pk_in_token (pk_in_token),
  .pk_out_pkt  (pk_out_pkt),
  .cpu_release (cpu_release),
  .flag_clr    (flag_clr),
  .bank_full   (bank_full),
  .bank_empty  (bank_empty),
  .rd_count    (rd_count),
  .zlp_req     (zlp_req),
  .flags       (flags),
  .irq         (irq)
);

// File: tb/ep_bank_guard_tb_top.sv
module ep_bank_guard_tb_top;
  localparam int BB    = 8;
  localparam int LW    = 11;
  localparam int CW    = $clog2(BB + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_iso, cfg_dir_in, cfg_two_banks;
  logic          pk_in_token, pk_out_pkt;
  logic [LW-1:0] pk_out_len;
  logic          cpu_validate, cpu_release;
  logic [2:0]    flag_clr, flag_en;
  logic          bank_full, bank_empty, zlp_req, irq;
  logic [CW-1:0] rd_count;
  logic [2:0]    flags;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ep_bank_guard #(.BANK_BYTES(BB), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_dir_in(cfg_dir_in),
    .cfg_two_banks(cfg_two_banks), .pk_in_token(pk_in_token),
    .pk_out_pkt(pk_out_pkt), .pk_out_len(pk_out_len),
    .cpu_validate(cpu_validate), .cpu_release(cpu_release),
    .flag_clr(flag_clr), .flag_en(flag_en), .bank_full(bank_full),
    .bank_empty(bank_empty), .rd_count(rd_count), .zlp_req(zlp_req),
    .flags(flags), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: strobes set by caller before, cleared after, outputs settled on return
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    pk_in_token = 0; pk_out_pkt = 0; cpu_validate = 0; cpu_release = 0;
    flag_clr = 0;
  endtask

  task automatic clear_all();
    flag_clr = 3'b111;
    cyc();
  endtask

  task automatic out_pkt(input int len);
    pk_out_len = LW'(len); pk_out_pkt = 1; cyc();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_iso = 0; cfg_dir_in = 1; cfg_two_banks = 1;
    pk_in_token = 0; pk_out_pkt = 0; pk_out_len = 0;
    cpu_validate = 0; cpu_release = 0; flag_clr = 0; flag_en = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 empty", int'(bank_empty), 1);
    chk("R1 full", int'(bank_full), 0);
    chk("R1 flags", int'(flags), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 zlp", int'(zlp_req), 0);
    chk("R1 count", int'(rd_count), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'({bank_empty, bank_full, flags}), 5'b10000);

    // R2 capacity in both bank modes, IN endpoint
    for (int tb2 = 0; tb2 < 2; tb2++) begin
      cfg_two_banks = tb2[0];
      for (int k = 1; k <= 3; k++) begin
        cpu_validate = 1; cyc();
        chk("R2 full", int'(bank_full), (k >= tb2 + 1) ? 1 : 0);
        chk("R2 empty", int'(bank_empty), 0);
      end
      // R11 OUT packet and release on IN endpoint ignored
      out_pkt(3);
      cpu_release = 1; cyc();
      chk("R11 ignored on IN", int'({bank_full, flags}), 4'b1000);
      for (int k = 0; k <= tb2; k++) begin
        pk_in_token = 1; cyc();
      end
      chk("R2 drained", int'(bank_empty), 1);
      // R4 non-iso token on empty
      pk_in_token = 1; cyc();
      chk("R4 no flag", int'(flags), 0);
      chk("R4 no zlp", int'(zlp_req), 0);
    end

    // R3 iso underflow with zlp pulse, R10 irq gating
    cfg_iso = 1;
    pk_in_token = 1; cyc();
    chk("R3 uf flag", int'(flags[0]), 1);
    chk("R3 zlp pulse", int'(zlp_req), 1);
    chk("R10 irq masked", int'(irq), 0);
    cyc();
    chk("R3 zlp one cycle", int'(zlp_req), 0);
    chk("R9 sticky", int'(flags[0]), 1);
    flag_en = 3'b001; #1;
    chk("R10 irq enabled", int'(irq), 1);
    flag_en = 3'b110; #1;
    chk("R10 irq other en", int'(irq), 0);
    // R9 clear wins over same-cycle set
    pk_in_token = 1; flag_clr = 3'b001; cyc();
    chk("R9 clear wins", int'(flags[0]), 0);
    chk("R10 irq off", int'(irq), 0);
    // valid token on non-empty iso: no underflow
    cpu_validate = 1; cyc();
    pk_in_token = 1; cyc();
    chk("R3 no uf when data", int'({flags[0], zlp_req}), 0);

    // R6 length sweep, all endpoint types and bank modes
    cfg_dir_in = 0;
    for (int iso = 0; iso < 2; iso++) begin
      for (int tb2 = 0; tb2 < 2; tb2++) begin
        cfg_iso = iso[0]; cfg_two_banks = tb2[0];
        for (int len = 0; len <= 2 * BB + 4; len++) begin
          clear_all();
          out_pkt(len);
          chk("R6 count", int'(rd_count), (len > BB) ? BB : len);
          chk("R6 ovf", int'(flags[1]), (len > BB) ? 1 : 0);
          chk("R6 rx", int'(flags[2]), 1);
          cpu_release = 1; cyc();
          chk("R6 released", int'(bank_empty), 1);
        end
      end
    end

    // R7 ping-pong order, R5 full discard
    cfg_two_banks = 1;
    for (int iso = 0; iso < 2; iso++) begin
      cfg_iso = iso[0];
      clear_all();
      out_pkt(3);
      out_pkt(5);
      chk("R5 full", int'(bank_full), 1);
      out_pkt(7);
      chk("R5 uf", int'(flags[0]), iso);
      chk("R5 still full", int'(bank_full), 1);
      chk("R7 first", int'(rd_count), 3);
      cpu_release = 1; cyc();
      chk("R7 second", int'(rd_count), 5);
      cpu_release = 1; cyc();
      chk("R5 dropped", int'(bank_empty), 1);
    end

    // R8 release on empty, R11 IN-side strobes on OUT endpoint
    clear_all();
    cpu_release = 1; cyc();
    chk("R8 release empty", int'({bank_empty, flags}), 4'b1000);
    pk_in_token = 1; cpu_validate = 1; cyc();
    chk("R11 ignored on OUT", int'({bank_empty, flags, zlp_req}), 5'b10000);
    // one-bank OUT: full after one
    cfg_two_banks = 0;
    out_pkt(2);
    chk("R2 one bank full", int'(bank_full), 1);
    out_pkt(4);
    chk("R5 one bank keep", int'(rd_count), 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule